// File: doc/BRIEF.md
# Timing Pulse Delay Line

This block shifts three single-cycle timing pulses (a level-1 trigger accept, a bunch-counter reset and an event-counter reset) later in time by a programmable number of clock cycles. All three share one delay setting. Pulses that enter together therefore leave together, and the spacing between them is kept. The trigger path has its own delay enable. The event-counter reset follows the enable of the bunch-counter reset. A lane whose enable is low still registers its pulse once, so it always has one clock of latency.

The delay store is a ring of 256 one-bit slots per lane, addressed by a free-running pointer. When a pulse enters an enabled lane, it is written into the slot that the pointer will reach after the requested number of cycles. Each cycle the slot under the pointer is read out and cleared. Because the landing slot is chosen when the pulse enters, a change to the delay setting only affects pulses that arrive after the change. The event-counter reset input goes through a rising-edge detector first. A level held for many cycles therefore gives exactly one output pulse.

Top module: `tsd_top`

## Requirements
- R1: With a lane's delay enable low, a pulse sampled at clock edge n appears on that lane's output right after edge n, which is one clock of latency.
- R2: With a lane's delay enable high and setting S (0 to 255), a pulse sampled at edge n appears right after edge n+S, which is S+1 clocks of latency. Setting 0 therefore matches the bypass timing.
- R3: The largest setting, 255, delays a pulse by 256 clocks, and the pulse still comes out exactly once.
- R4: The trigger lane uses the trigger enable. Both the bunch-counter reset lane and the event-counter reset lane use the bunch-counter enable.
- R5: Each rising edge of the event-counter reset input gives exactly one single-cycle output pulse, however long the input stays high. A new rising edge after a low cycle gives another pulse.
- R6: On the trigger and bunch-counter reset lanes, every input cycle that is high gives one output cycle that is high. A three-cycle trigger comes out as three cycles.
- R7: Pulses that enter enabled lanes in the same cycle leave in the same cycle.
- R8: A change of the delay setting applies only to pulses entering after the change. A pulse already in flight keeps the delay it was given when it entered.
- R9: An active-low reset clears all three outputs and discards every pulse in flight. No pulse appears after reset is released unless a new one is applied.
- R10: Two pulses on one lane that are scheduled for the same output cycle, for example after the setting is reduced by one, merge into a single output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l1a_in | input | 1 | Trigger accept pulse in |
| bcr_in | input | 1 | Bunch-counter reset pulse in |
| ecr_in | input | 1 | Event-counter reset in (rising edge counts) |
| delay_set | input | 8 | Shared delay setting S, latency S+1 clocks when enabled |
| l1a_dly_en | input | 1 | Trigger lane delay enable |
| bcr_dly_en | input | 1 | Delay enable for bunch-counter and event-counter reset lanes |
| l1a_out | output | 1 | Delayed trigger accept pulse |
| bcr_out | output | 1 | Delayed bunch-counter reset pulse |
| ecr_out | output | 1 | Delayed event-counter reset pulse |

## Verification
A slot bit that is stuck or left uncleared shows up as a spurious pulse once every 256 cycles on one output. A pointer that skips or stalls moves every delayed pulse away from cycle n+S, and this shows on the first pulse sent through the ring. An edge detector that holds the wrong state either doubles an event-counter reset or swallows one at its next rising edge. A reset that does not reach the ring lets a pulse in flight appear up to 256 cycles after release. Because of this, each stimulus window runs for more than the full ring length.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

  localparam int NUM_LANES = 3;

  typedef enum logic [1:0] {
    LANE_L1A = 2'd0,
    LANE_BCR = 2'd1,
    LANE_ECR = 2'd2
  } lane_e;

  // Lanes other than the trigger follow the bunch-counter enable (R4).
  function automatic bit lane_uses_bcr_enable(int idx);
    return idx != int'(LANE_L1A);
  endfunction

  // Only the event-counter reset lane is edge-qualified (R5).
  function automatic bit lane_is_edge_qualified(int idx);
    return idx == int'(LANE_ECR);
  endfunction

endpackage

// File: rtl/tsd_ring_ptr.sv
module tsd_ring_ptr #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] rd_ptr
);

  function automatic logic [PW-1:0] ptr_next(logic [PW-1:0] p);
    if (int'(p) >= DEPTH - 1) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_ptr <= '0;
    else        rd_ptr <= ptr_next(rd_ptr);
  end

  // The pointer advances by exactly one slot per clock (R2).
  assert_ptr_steps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rd_ptr == ptr_next($past(rd_ptr)));

endmodule

// File: rtl/tsd_rise_once.sv
module tsd_rise_once (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise_out
);

  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise_out = level_in & ~level_q;

  // A held level must not give back-to-back qualified pulses (R5).
  assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise_out |=> !rise_out);

endmodule

// File: rtl/tsd_lane.sv
module tsd_lane #(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pulse_in,
  input  logic          dly_en,
  input  logic [PW-1:0] dly_set,
  input  logic [PW-1:0] rd_ptr,
  output logic          pulse_out,
  output logic          line_busy
);

  // Settings beyond the ring length are held at the longest delay.
  function automatic logic [PW-1:0] clamp_set(logic [PW-1:0] d);
    if (int'(d) > DEPTH - 1) return PW'(DEPTH - 1);
    return d;
  endfunction

  // Slot the pointer reaches d cycles from now.
  function automatic logic [PW-1:0] land_slot(logic [PW-1:0] p, logic [PW-1:0] d);
    int s;
    s = int'(p) + int'(d);
    if (s >= DEPTH) s = s - DEPTH;
    return PW'(s);
  endfunction

  logic [DEPTH-1:0] ring;
  logic [PW-1:0]    d_eff;
  logic [PW-1:0]    slot;
  logic             zero_set;
  logic             to_ring;
  logic             to_out_now;
  logic             ring_tail;

  assign d_eff      = clamp_set(dly_set);
  assign zero_set   = (d_eff == '0);
  assign to_ring    = pulse_in & dly_en & ~zero_set;
  assign to_out_now = pulse_in & ~to_ring;
  assign slot       = land_slot(rd_ptr, d_eff);
  assign ring_tail  = ring[rd_ptr];
  assign line_busy  = |ring;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring      <= '0;
      pulse_out <= 1'b0;
    end else begin
      ring[rd_ptr] <= 1'b0;
      if (to_ring) ring[slot] <= 1'b1;
      pulse_out <= ring_tail | to_out_now;
    end
  end

  // Bypass lane: one clock of latency (R1).
  assert_bypass_one_clock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!dly_en && !line_busy) |=> pulse_out == $past(pulse_in));

  // Enabled lane with setting 0: same single clock (R2).
  assert_zero_setting_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_en && dly_set == '0 && !line_busy) |=> pulse_out == $past(pulse_in));

  // Reset leaves nothing in flight and a quiet output (R9).
  assert_reset_clears_R9: assert property (@(posedge clk)
    !rst_n |=> (!pulse_out && !line_busy));

endmodule

// File: rtl/tsd_top.sv
module tsd_top
  import tsd_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l1a_in,
  input  logic          bcr_in,
  input  logic          ecr_in,
  input  logic [PW-1:0] delay_set,
  input  logic          l1a_dly_en,
  input  logic          bcr_dly_en,
  output logic          l1a_out,
  output logic          bcr_out,
  output logic          ecr_out
);

  logic [PW-1:0]        rd_ptr;
  logic                 ecr_rise;
  logic [NUM_LANES-1:0] lane_raw;
  logic [NUM_LANES-1:0] lane_in;
  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_LANES-1:0] lane_out;
  logic [NUM_LANES-1:0] lane_busy;

  tsd_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_ptr (rd_ptr)
  );

  tsd_rise_once u_ecr_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (ecr_in),
    .rise_out (ecr_rise)
  );

  assign lane_raw[LANE_L1A] = l1a_in;
  assign lane_raw[LANE_BCR] = bcr_in;
  assign lane_raw[LANE_ECR] = ecr_in;

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    if (lane_is_edge_qualified(i)) begin : g_edge
      assign lane_in[i] = ecr_rise;
    end else begin : g_level
      assign lane_in[i] = lane_raw[i];
    end

    if (lane_uses_bcr_enable(i)) begin : g_bcr_en
      assign lane_en[i] = bcr_dly_en;
    end else begin : g_l1a_en
      assign lane_en[i] = l1a_dly_en;
    end

    tsd_lane #(.DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .pulse_in  (lane_in[i]),
      .dly_en    (lane_en[i]),
      .dly_set   (delay_set),
      .rd_ptr    (rd_ptr),
      .pulse_out (lane_out[i]),
      .line_busy (lane_busy[i])
    );
  end

  assign l1a_out = lane_out[LANE_L1A];
  assign bcr_out = lane_out[LANE_BCR];
  assign ecr_out = lane_out[LANE_ECR];

  // Event-counter reset is bypassed together with the bunch-counter reset (R4).
  assert_ecr_follows_bcr_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bcr_dly_en && !lane_busy[LANE_ECR] && ecr_rise) |=> ecr_out);

  // Trigger and bunch-counter reset entering together in bypass leave together (R7).
  assert_bypass_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!l1a_dly_en && !bcr_dly_en && lane_busy[LANE_L1A:LANE_BCR] == '0 && l1a_in && bcr_in)
      |=> (l1a_out && bcr_out));

endmodule

// File: tb/tb_tsd_top.sv
module tb_tsd_top;

  localparam int W = 300;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l1a_in = 1'b0, bcr_in = 1'b0, ecr_in = 1'b0;
  logic [7:0] delay_set = 8'd0;
  logic       l1a_dly_en = 1'b0, bcr_dly_en = 1'b0;
  logic       l1a_out, bcr_out, ecr_out;

  int n_checks = 0;
  int n_fail = 0;

  bit st_t [W];
  bit st_b [W];
  bit st_e [W];
  int st_d [W];
  int first_t, first_b, first_e, cnt_t, cnt_b, cnt_e;

  always #4 clk = ~clk;

  tsd_top dut (
    .clk(clk), .rst_n(rst_n), .l1a_in(l1a_in), .bcr_in(bcr_in), .ecr_in(ecr_in),
    .delay_set(delay_set), .l1a_dly_en(l1a_dly_en), .bcr_dly_en(bcr_dly_en),
    .l1a_out(l1a_out), .bcr_out(bcr_out), .ecr_out(ecr_out)
  );

  // {setting, trigger enable, bunch-counter enable}
  localparam logic [9:0] VEC [8] = '{
    {8'd0,   1'b1, 1'b1},
    {8'd1,   1'b1, 1'b1},
    {8'd5,   1'b1, 1'b0},
    {8'd5,   1'b0, 1'b1},
    {8'd255, 1'b1, 1'b1},
    {8'd17,  1'b0, 1'b0},
    {8'd100, 1'b1, 1'b1},
    {8'd3,   1'b1, 1'b1}
  };

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_stim(int d);
    for (int c = 0; c < W; c++) begin
      st_t[c] = 1'b0; st_b[c] = 1'b0; st_e[c] = 1'b0; st_d[c] = d;
    end
  endtask

  // Starts and ends at a falling edge; index c is the sample after rising edge c.
  task automatic run(int n);
    first_t = -1; first_b = -1; first_e = -1;
    cnt_t = 0; cnt_b = 0; cnt_e = 0;
    for (int c = 0; c < n; c++) begin
      l1a_in = st_t[c]; bcr_in = st_b[c]; ecr_in = st_e[c];
      delay_set = 8'(st_d[c]);
      @(negedge clk);
      if (l1a_out) begin cnt_t++; if (first_t < 0) first_t = c; end
      if (bcr_out) begin cnt_b++; if (first_b < 0) first_b = c; end
      if (ecr_out) begin cnt_e++; if (first_e < 0) first_e = c; end
    end
    l1a_in = 1'b0; bcr_in = 1'b0; ecr_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: quiet outputs after reset
    check("R9", "l1a_out after reset", int'(l1a_out), 0);
    check("R9", "bcr_out after reset", int'(bcr_out), 0);
    check("R9", "ecr_out after reset", int'(ecr_out), 0);

    // Table: R1 R2 R3 R4 R5
    for (int v = 0; v < 8; v++) begin
      int d, et, eb;
      d = int'(VEC[v][9:2]); et = int'(VEC[v][1]); eb = int'(VEC[v][0]);
      l1a_dly_en = VEC[v][1]; bcr_dly_en = VEC[v][0];
      clear_stim(d);
      st_t[0] = 1'b1; st_b[1] = 1'b1;
      st_e[2] = 1'b1; st_e[3] = 1'b1; st_e[4] = 1'b1;
      run(270);
      check("R2", "l1a arrival", first_t, et ? d : 0);
      check("R3", "l1a count", cnt_t, 1);
      check("R4", "bcr arrival", first_b, 1 + (eb ? d : 0));
      check("R1", "bcr count", cnt_b, 1);
      check("R4", "ecr arrival", first_e, 2 + (eb ? d : 0));
      check("R5", "ecr count", cnt_e, 1);
    end

    // R9: reset discards a pulse in flight
    l1a_dly_en = 1'b1; bcr_dly_en = 1'b1;
    clear_stim(50); st_t[0] = 1'b1;
    run(10);
    check("R9", "l1a before reset", cnt_t, 0);
    do_reset();
    clear_stim(50);
    run(270);
    check("R9", "l1a after reset", cnt_t, 0);

    // R8: setting change affects only later pulses
    clear_stim(3); st_d[0] = 20; st_t[0] = 1'b1; st_b[1] = 1'b1;
    run(270);
    check("R8", "in-flight l1a arrival", first_t, 20);
    check("R8", "later bcr arrival", first_b, 4);

    // R10: two pulses landing in one cycle merge
    clear_stim(9); st_d[0] = 10; st_t[0] = 1'b1; st_t[1] = 1'b1;
    run(270);
    check("R10", "merged l1a arrival", first_t, 10);
    check("R10", "merged l1a count", cnt_t, 1);

    // R6: multi-cycle levels keep their width on level lanes
    l1a_dly_en = 1'b1; bcr_dly_en = 1'b0;
    clear_stim(4); st_t[0] = 1'b1; st_t[1] = 1'b1; st_t[2] = 1'b1;
    st_b[0] = 1'b1; st_b[1] = 1'b1;
    run(270);
    check("R6", "l1a width start", first_t, 4);
    check("R6", "l1a width", cnt_t, 3);
    check("R6", "bcr bypass width", cnt_b, 2);

    // R5: re-arm after a low cycle, bypass
    clear_stim(4); st_e[0] = 1'b1;
    for (int c = 2; c < 7; c++) st_e[c] = 1'b1;
    run(270);
    check("R5", "ecr re-arm first", first_e, 0);
    check("R5", "ecr re-arm count", cnt_e, 2);

    // R5: long level, delayed
    bcr_dly_en = 1'b1;
    clear_stim(7);
    for (int c = 0; c < 20; c++) st_e[c] = 1'b1;
    run(270);
    check("R5", "long ecr arrival", first_e, 7);
    check("R5", "long ecr count", cnt_e, 1);

    // R7: all three together stay together
    clear_stim(9); st_t[0] = 1'b1; st_b[0] = 1'b1; st_e[0] = 1'b1;
    run(270);
    check("R7", "l1a aligned", first_t, 9);
    check("R7", "bcr aligned", first_b, 9);
    check("R7", "ecr aligned", first_e, 9);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule